// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Arbiter

The arbiter takes a parameterised set of maskable interrupt request lines and chooses at most one of them to hand to a CPU core. Each source has three things: a request flag that latches a one-cycle request pulse, a mask bit, and a single priority bit, where 0 selects high priority and 1 selects low priority. A global enable flag decides whether any request can be taken at all. An in-service flag records the priority level that is being serviced. When that flag is 0, a high-priority handler is running and low-priority sources are held back.

When the arbiter accepts a request, it pulses an acknowledge strobe together with the vector index of the source. It then issues two context-save strobes, status word first and program counter second, and finally a vector-load strobe. At acceptance it clears the global enable flag and copies the source's priority bit into the in-service flag. The values these two flags had before acceptance go onto a small save stack. A return-from-interrupt pulse pops them back, so nested service unwinds in LIFO order. After the vector-load strobe, no further acknowledge is issued until the CPU raises its ready input.

Top module: `irq_arbiter`

## Requirements
- R1: A one-cycle pulse on `irq_req[i]` sets request flag i, visible on `pending[i]`. The flag stays set until that source is accepted, and a held-off request is accepted once it becomes acceptable.
- R2: A source whose `irq_mask` bit is 1 is never accepted, but its request stays pending. Once the mask bit returns to 0, the pending request is accepted.
- R3: No request is accepted while `gie` is 0.
- R4: While `isp` is 0, a source with `irq_prio` bit 1 (low priority) is not accepted, and a source with priority bit 0 still is.
- R5: Among eligible requests, any source with priority bit 0 wins over every source with priority bit 1, whatever their indices.
- R6: Among eligible requests with equal priority bits, the lowest index wins.
- R7: In the cycle `ack` is 1, `gie` is 0, `isp` equals the accepted source's priority bit, and that source's `pending` bit is 0.
- R8: If `ack` is high in cycle T (for one cycle only), then `ctx_save` is high with `ctx_sel`=0 (status word) in T+1. `ctx_save` is high with `ctx_sel`=1 (program counter) in T+2. `vec_load` is high in T+3, and `vec_idx` holds the accepted index through T+3.
- R9: After `vec_load`, no new `ack` appears until `cpu_ready` has been sampled high. The earliest possible `ack` is two cycles after the cycle in which `cpu_ready` is high.
- R10: A `reti` pulse restores `gie` and `isp` to the values they had just before the most recent unreturned acceptance, in LIFO order. A `reti` with nothing saved changes neither flag.
- R11: After reset, `gie`=0, `isp`=1, `pending`=0, and `ack`, `ctx_save` and `vec_load` are 0.
- R12: When several flag controls arrive in the same cycle, `reti` (with an entry saved) takes precedence over `gie_clr`, and `gie_clr` takes precedence over `gie_set`. No request is accepted in a cycle where any of the three is high.
- R13: When `NEST_DEPTH` acceptances are unreturned, no further request is accepted until a `reti` frees an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | NUM_SRC | One-cycle request pulses, one per source |
| irq_mask | input | NUM_SRC | Per-source mask, 1 blocks acceptance |
| irq_prio | input | NUM_SRC | Per-source priority bit, 0 high, 1 low |
| gie_set | input | 1 | Set the global enable flag |
| gie_clr | input | 1 | Clear the global enable flag |
| reti | input | 1 | Return from interrupt, pops saved flags |
| cpu_ready | input | 1 | CPU can take the next acknowledge |
| ack | output | 1 | One-cycle acceptance strobe |
| vec_idx | output | IDX_W | Index of the accepted source |
| ctx_save | output | 1 | Context-save strobe |
| ctx_sel | output | 1 | 0 status word, 1 program counter |
| vec_load | output | 1 | Load program counter from vector `vec_idx` |
| gie | output | 1 | Global enable flag |
| isp | output | 1 | In-service priority flag |
| pending | output | NUM_SRC | Latched request flags |

## Verification
The assertions assume that every input holds a defined level from reset onward. They also assume that `reti` is given only for a service the arbiter actually granted, since the save stack is the only record of nesting. The bench changes inputs only on the falling clock edge and holds request lines for exactly one cycle. It pulses `reti` only after the matching vector-load strobe, and it never pushes more unreturned acceptances than the stack can hold, so the overflow and ordering properties stay inside their stated premises.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SAVE_SW = 3'd1,
    ST_SAVE_PC = 3'd2,
    ST_LOAD    = 3'd3,
    ST_WAIT    = 3'd4
  } arb_state_e;

  typedef struct packed {
    logic gie;
    logic isp;
  } ctx_t;

endpackage

// File: rtl/irq_req_flags.sv
module irq_req_flags #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flags_o
);

  logic [NUM_SRC-1:0] flags_q;
  logic [NUM_SRC-1:0] flags_d;

  // A new pulse wins over a clear arriving in the same cycle.
  always_comb begin
    flags_d = (flags_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hold_chk
    assert_pending_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && !clr_i[i]) |=> flags_q[i]);
  end

endmodule

// File: rtl/irq_prienc.sv
module irq_prienc #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] vec_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);

  // Lowest set index wins: scan downward so the last hit is the lowest.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] flags_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [NUM_SRC-1:0] prio_i,
  input  logic               isp_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               prio_o
);

  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] elig_hi;
  logic [NUM_SRC-1:0] elig_lo;
  logic               hi_found;
  logic               lo_found;
  logic [IDX_W-1:0]   hi_idx;
  logic [IDX_W-1:0]   lo_idx;

  always_comb begin
    elig    = flags_i & ~mask_i;
    elig_hi = elig & ~prio_i;
    // Low-priority sources compete only while no high-level service runs.
    elig_lo = isp_i ? (elig & prio_i) : '0;
  end

  irq_prienc #(.NUM_SRC(NUM_SRC)) u_enc_hi (
    .vec_i   (elig_hi),
    .found_o (hi_found),
    .idx_o   (hi_idx)
  );

  irq_prienc #(.NUM_SRC(NUM_SRC)) u_enc_lo (
    .vec_i   (elig_lo),
    .found_o (lo_found),
    .idx_o   (lo_idx)
  );

  always_comb begin
    valid_o = hi_found | lo_found;
    idx_o   = hi_found ? hi_idx : lo_idx;
    prio_o  = ~hi_found;
  end

endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic pop_i,
  input  ctx_t push_data_i,
  output ctx_t top_o,
  output logic full_o,
  output logic empty_o
);

  ctx_t          mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [AW-1:0] wr_idx;
  logic [AW-1:0] rd_idx;
  logic [CW-1:0] cnt_m1;

  always_comb begin
    cnt_m1  = cnt_q - CW'(1);
    wr_idx  = AW'(cnt_q);
    rd_idx  = AW'(cnt_m1);
    full_o  = (cnt_q == CW'(DEPTH));
    empty_o = (cnt_q == '0);
    top_o   = mem_q[rd_idx];
    cnt_d   = cnt_q;
    if (push_i && !full_o)      cnt_d = cnt_q + CW'(1);
    else if (pop_i && !empty_o) cnt_d = cnt_m1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Storage needs no reset: an entry is read only after it is written.
  always_ff @(posedge clk) begin
    if (push_i && !full_o) mem_q[wr_idx] <= push_data_i;
  end

  assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int NEST_DEPTH = 4,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] irq_mask,
  input  logic [NUM_SRC-1:0] irq_prio,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  logic               reti,
  input  logic               cpu_ready,
  output logic               ack,
  output logic [IDX_W-1:0]   vec_idx,
  output logic               ctx_save,
  output logic               ctx_sel,
  output logic               vec_load,
  output logic               gie,
  output logic               isp,
  output logic [NUM_SRC-1:0] pending
);

  // Reset synchroniser: asserts at once, releases on the second edge.
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  arb_state_e         st_q, st_d;
  logic               gie_q, gie_d;
  logic               isp_q, isp_d;
  logic               flag_en;
  logic               ack_q, ack_d;
  logic               save_q, save_d;
  logic               sel_q, sel_d;
  logic               load_q, load_d;
  logic [IDX_W-1:0]   vec_q, vec_d;
  logic               vec_en;

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] clr_vec;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  logic               win_prio;
  logic               stk_full;
  logic               stk_empty;
  ctx_t               stk_top;
  ctx_t               stk_in;
  logic               accept;
  logic               pop;
  logic               ctl_busy;

  irq_req_flags #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_i   (irq_req),
    .clr_i   (clr_vec),
    .flags_o (pend)
  );

  irq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .flags_i (pend),
    .mask_i  (irq_mask),
    .prio_i  (irq_prio),
    .isp_i   (isp_q),
    .valid_o (win_valid),
    .idx_o   (win_idx),
    .prio_o  (win_prio)
  );

  irq_ctx_stack #(.DEPTH(NEST_DEPTH)) u_stack (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .push_i      (accept),
    .pop_i       (pop),
    .push_data_i (stk_in),
    .top_o       (stk_top),
    .full_o      (stk_full),
    .empty_o     (stk_empty)
  );

  // Acceptance decision and request-flag clear.
  always_comb begin
    ctl_busy = reti | gie_set | gie_clr;
    accept   = (st_q == ST_IDLE) && gie_q && win_valid && !stk_full && !ctl_busy;
    pop      = reti && !stk_empty;
    stk_in   = '{gie: gie_q, isp: isp_q};
    clr_vec  = '0;
    if (accept) clr_vec[win_idx] = 1'b1;
  end

  // Global enable and in-service flags.
  always_comb begin
    gie_d = gie_q;
    isp_d = isp_q;
    if (accept) begin
      gie_d = 1'b0;
      isp_d = win_prio;
    end else if (pop) begin
      gie_d = stk_top.gie;
      isp_d = stk_top.isp;
    end else if (gie_clr) begin
      gie_d = 1'b0;
    end else if (gie_set) begin
      gie_d = 1'b1;
    end
    flag_en = accept | pop | gie_clr | gie_set;
  end

  // Service sequence and registered strobes.
  always_comb begin
    st_d   = st_q;
    ack_d  = 1'b0;
    save_d = 1'b0;
    sel_d  = 1'b0;
    load_d = 1'b0;
    vec_d  = win_idx;
    vec_en = accept;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          ack_d = 1'b1;
          st_d  = ST_SAVE_SW;
        end
      end
      ST_SAVE_SW: begin
        save_d = 1'b1;
        sel_d  = 1'b0;
        st_d   = ST_SAVE_PC;
      end
      ST_SAVE_PC: begin
        save_d = 1'b1;
        sel_d  = 1'b1;
        st_d   = ST_LOAD;
      end
      ST_LOAD: begin
        load_d = 1'b1;
        st_d   = ST_WAIT;
      end
      ST_WAIT: begin
        if (cpu_ready) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_IDLE;
      ack_q  <= 1'b0;
      save_q <= 1'b0;
      sel_q  <= 1'b0;
      load_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ack_q  <= ack_d;
      save_q <= save_d;
      sel_q  <= sel_d;
      load_q <= load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gie_q <= 1'b0;
      isp_q <= 1'b1;
    end else if (flag_en) begin
      gie_q <= gie_d;
      isp_q <= isp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  vec_q <= '0;
    else if (vec_en)  vec_q <= vec_d;
  end

  assign ack      = ack_q;
  assign vec_idx  = vec_q;
  assign ctx_save = save_q;
  assign ctx_sel  = sel_q;
  assign vec_load = load_q;
  assign gie      = gie_q;
  assign isp      = isp_q;
  assign pending  = pend;

  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ack_q |=> !ack_q);

  assert_save_order_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ack_q |=> (save_q && !sel_q));

  assert_pc_after_sw_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (save_q && !sel_q) |=> (save_q && sel_q));

  assert_gie_cleared_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ack_q |-> !gie_q);

  assert_low_blocked_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack_q && !$past(isp_q)) |-> !isp_q);

  assert_wait_ready_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == ST_WAIT && !cpu_ready) |=> !ack_q);

endmodule

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;

  localparam int N     = 8;
  localparam int IW    = 3;
  localparam int DEPTH = 4;

  // req, mask, prio, expect ack, expect index
  localparam logic [27:0] TBL [8] = '{
    {8'h01, 8'h00, 8'h00, 1'b1, 3'd0},
    {8'h90, 8'h00, 8'h00, 1'b1, 3'd4},
    {8'h81, 8'h00, 8'h01, 1'b1, 3'd7},
    {8'hFF, 8'h00, 8'h0F, 1'b1, 3'd4},
    {8'h06, 8'h02, 8'h00, 1'b1, 3'd2},
    {8'h0F, 8'h0F, 8'h00, 1'b0, 3'd0},
    {8'hC0, 8'h00, 8'hC0, 1'b1, 3'd6},
    {8'h00, 8'h00, 8'h00, 1'b0, 3'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_req, irq_mask, irq_prio;
  logic          gie_set, gie_clr, reti, cpu_ready;
  logic          ack, ctx_save, ctx_sel, vec_load, gie, isp;
  logic [IW-1:0] vec_idx;
  logic [N-1:0]  pending;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_arbiter #(.NUM_SRC(N), .NEST_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_mask(irq_mask),
    .irq_prio(irq_prio), .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti),
    .cpu_ready(cpu_ready), .ack(ack), .vec_idx(vec_idx), .ctx_save(ctx_save),
    .ctx_sel(ctx_sel), .vec_load(vec_load), .gie(gie), .isp(isp), .pending(pending)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_req = '0; irq_mask = '0; irq_prio = '0;
    gie_set = 1'b0; gie_clr = 1'b0; reti = 1'b0; cpu_ready = 1'b0;
    repeat (2) nxt();
    rst_n = 1'b1;
    repeat (4) nxt();
  endtask

  task automatic wait_ack(output bit got, output int idx);
    got = 1'b0;
    idx = -1;
    for (int k = 0; k < 8; k++) begin
      nxt();
      if (ack) begin
        got = 1'b1;
        idx = int'(vec_idx);
        break;
      end
    end
  endtask

  task automatic serve();
    repeat (3) nxt();
    cpu_ready = 1'b1;
    nxt();
    cpu_ready = 1'b0;
  endtask

  task automatic no_ack(input int cycles, output int hits);
    hits = 0;
    for (int k = 0; k < cycles; k++) begin
      nxt();
      if (ack) hits++;
    end
  endtask

  task automatic pulse_reti();
    reti = 1'b1;
    nxt();
    reti = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    bit got;
    int idx;
    int hits;

    // R11: reset state
    do_reset();
    check(gie == 1'b0, "R11 gie", int'(gie), 0);
    check(isp == 1'b1, "R11 isp", int'(isp), 1);
    check(pending == '0, "R11 pending", int'(pending), 0);
    check({ack, ctx_save, vec_load} == 3'b000, "R11 strobes",
          int'({ack, ctx_save, vec_load}), 0);

    // Table walk: R2, R5, R6 selection patterns
    for (int v = 0; v < 8; v++) begin
      do_reset();
      irq_mask = TBL[v][19:12];
      irq_prio = TBL[v][11:4];
      irq_req  = TBL[v][27:20];
      gie_set  = 1'b1;
      nxt();
      irq_req = '0;
      gie_set = 1'b0;
      nxt();
      check(ack == TBL[v][3], $sformatf("R5/R6/R2 vector %0d ack", v),
            int'(ack), int'(TBL[v][3]));
      if (TBL[v][3])
        check(vec_idx == TBL[v][2:0], $sformatf("R5/R6 vector %0d index", v),
              int'(vec_idx), int'(TBL[v][2:0]));
    end

    // R7, R8, R9, R10: full sequence with nesting
    do_reset();
    irq_prio = '0;
    irq_req  = 8'h08;
    gie_set  = 1'b1;
    nxt();
    irq_req = '0;
    gie_set = 1'b0;
    check(pending[3] == 1'b1, "R1 flag latched", int'(pending[3]), 1);
    nxt();
    check(ack && vec_idx == 3'd3, "R7 ack index", int'(vec_idx), 3);
    check(gie == 1'b0 && isp == 1'b0, "R7 flags at ack", int'({gie, isp}), 0);
    check(pending[3] == 1'b0, "R7 flag cleared", int'(pending[3]), 0);
    nxt();
    check(!ack && ctx_save && !ctx_sel, "R8 status save", int'({ack, ctx_save, ctx_sel}), 2);
    nxt();
    check(ctx_save && ctx_sel, "R8 pc save", int'({ctx_save, ctx_sel}), 3);
    nxt();
    check(vec_load && !ctx_save && vec_idx == 3'd3, "R8 vector load",
          int'({vec_load, ctx_save}), 2);
    gie_set = 1'b1;
    irq_req = 8'h20;
    nxt();
    gie_set = 1'b0;
    irq_req = '0;
    no_ack(4, hits);
    check(hits == 0, "R9 held without ready", hits, 0);
    cpu_ready = 1'b1;
    nxt();
    cpu_ready = 1'b0;
    check(!ack, "R9 not same cycle", int'(ack), 0);
    nxt();
    check(ack && vec_idx == 3'd5, "R9 ack after ready", int'(vec_idx), 5);
    serve();
    pulse_reti();
    check(gie == 1'b1 && isp == 1'b0, "R10 first pop", int'({gie, isp}), 2);
    pulse_reti();
    check(gie == 1'b1 && isp == 1'b1, "R10 second pop", int'({gie, isp}), 3);
    gie_clr = 1'b1;
    nxt();
    gie_clr = 1'b0;
    pulse_reti();
    check(gie == 1'b0 && isp == 1'b1, "R10 empty pop no effect", int'({gie, isp}), 1);

    // R3: disabled globally, then enabled
    do_reset();
    irq_req = 8'h20;
    nxt();
    irq_req = '0;
    no_ack(5, hits);
    check(hits == 0, "R3 no ack while disabled", hits, 0);
    gie_set = 1'b1;
    nxt();
    gie_set = 1'b0;
    wait_ack(got, idx);
    check(got && idx == 5, "R3 accepted after enable", idx, 5);

    // R2 then R1: masked request waits, accepted once unmasked
    do_reset();
    irq_mask = 8'h08;
    irq_req  = 8'h08;
    gie_set  = 1'b1;
    nxt();
    irq_req = '0;
    gie_set = 1'b0;
    no_ack(5, hits);
    check(hits == 0 && pending[3], "R2 masked held", hits, 0);
    irq_mask = '0;
    wait_ack(got, idx);
    check(got && idx == 3, "R2 unmasked accepted", idx, 3);

    // R4: high-level service blocks low sources
    do_reset();
    irq_prio = 8'h01;
    irq_req  = 8'h02;
    gie_set  = 1'b1;
    nxt();
    irq_req = '0;
    gie_set = 1'b0;
    wait_ack(got, idx);
    check(got && idx == 1 && isp == 1'b0, "R7 high accepted isp", int'(isp), 0);
    serve();
    irq_req = 8'h01;
    gie_set = 1'b1;
    nxt();
    irq_req = '0;
    gie_set = 1'b0;
    no_ack(6, hits);
    check(hits == 0 && pending[0], "R4 low blocked", hits, 0);
    irq_req = 8'h40;
    nxt();
    irq_req = '0;
    wait_ack(got, idx);
    check(got && idx == 6, "R4 high still accepted", idx, 6);
    serve();
    pulse_reti();
    no_ack(4, hits);
    check(hits == 0 && gie && !isp, "R4 still blocked after first pop", hits, 0);
    pulse_reti();
    check(gie && isp, "R10 restored outer flags", int'({gie, isp}), 3);
    wait_ack(got, idx);
    check(got && idx == 0, "R1 held request accepted", idx, 0);

    // R12: control precedence and deferred acceptance
    do_reset();
    gie_set = 1'b1;
    gie_clr = 1'b1;
    nxt();
    gie_clr = 1'b0;
    check(gie == 1'b0, "R12 clear beats set", int'(gie), 0);
    irq_req = 8'h04;
    nxt();
    irq_req = '0;
    check(gie == 1'b1, "R12 set alone", int'(gie), 1);
    no_ack(3, hits);
    check(hits == 0, "R12 accept deferred", hits, 0);
    gie_set = 1'b0;
    wait_ack(got, idx);
    check(got && idx == 2, "R12 accept after controls drop", idx, 2);

    // R13: save stack full blocks acceptance
    do_reset();
    for (int k = 0; k < DEPTH; k++) begin
      irq_req = N'(1) << k;
      gie_set = 1'b1;
      nxt();
      irq_req = '0;
      gie_set = 1'b0;
      wait_ack(got, idx);
      check(got && idx == k, "R13 fill stack", idx, k);
      serve();
    end
    irq_req = 8'h10;
    gie_set = 1'b1;
    nxt();
    irq_req = '0;
    gie_set = 1'b0;
    no_ack(6, hits);
    check(hits == 0 && pending[4], "R13 blocked when full", hits, 0);
    pulse_reti();
    wait_ack(got, idx);
    check(got && idx == 4, "R13 accepted after pop", idx, 4);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule